// File: doc/BRIEF.md
# Latched Real-Time Clock Register File

This block keeps time of day for a cartridge: live seconds, minutes, hours and a 9-bit day count that advance once for every pulse on a one-per-second tick enable. Software never reads the live counters directly. Instead it performs a two-write handshake on the latch page (write 0, then 1). The rising step takes a snapshot of all live fields into five latched registers, and those registers stay frozen for reading while the clock keeps running.

The CPU side is a simple strobe bus. The upper three address bits select a page. Page 2 is the bank-select page. Page 3 is the latch page. Page 5 is the external-RAM window. A write to the bank-select page either chooses an external RAM bank or maps one of the five clock registers into the RAM window. With a clock register mapped, reads from the window return the latched copy of that register, and writes to the window load the live counter behind it. Reads are registered and appear one cycle after the read strobe.

Register numbering is as follows: 0 seconds, 1 minutes, 2 hours, 3 day count bits 7:0, and 4 day high. In register 4, bit 0 is day bit 8 and bit 7 is the overflow flag.

Top module: `rtc_latch_top`

## Requirements
- R1: On each cycle with `tick` high and no live-register write, seconds advance; from 59 seconds wrap to 0 and carry into minutes, which wrap from 59 to 0 and carry into hours, which wrap from 23 to 0 and carry into the day count.
- R2: The day count is 9 bits; register 3 holds bits 7:0, bit 0 of register 4 holds bit 8, and bits 6:1 of register 4 (and bits 7:6 of seconds/minutes, 7:5 of hours) read as 0.
- R3: When the day count is 0x1FF and receives a carry it becomes 0 and bit 7 of register 4 is set; that bit stays set through further ticks until software writes register 4 with bit 7 clear.
- R4: A write to page 2 with data 0x00–0x03 sets `ram_bank` to that value and clears `clk_access`; data 0x08–0x0C selects clock register data−8 and sets `clk_access`, leaving `ram_bank` unchanged; any other data changes neither.
- R5: A write of 0x01 to page 3 while unlatched copies all live fields into the latched registers and marks the clock latched; later ticks do not change what reads return.
- R6: A write of 0x00 to page 3 while latched clears the latched mark; a write of 0x01 while latched takes no new snapshot, and every other page-3 value does nothing.
- R7: Synchronous reset clears all live counters, the overflow flag, latched registers, latched mark, `clk_access`, `ram_bank` and `rd_data`.
- R8: A read strobe on page 5 with `clk_access` set returns the selected latched register on `rd_data` one cycle later; with `clk_access` clear it returns 0xFF.
- R9: A write to page 5 with `clk_access` set loads the selected live field from the data (register 4: bit 0 to day bit 8, bit 7 to the flag); in that cycle a tick is not applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle pulse per elapsed second |
| cpu_wr | input | 1 | Write strobe |
| cpu_rd | input | 1 | Read strobe |
| cpu_page | input | 3 | CPU address bits 15:13 (page) |
| cpu_wdata | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| ram_bank | output | 2 | Selected external RAM bank |
| clk_access | output | 1 | High while a clock register is mapped into the RAM window |

## Verification
A wrong carry or wrap in the live chain stays hidden until the next snapshot, so the bench always latches and reads back after the ticks it applies. A wrong field then shows in `rd_data` on the cycle after the read strobe. A latched mark that is stuck or cleared too early shows up as a read that follows the ticks, or as a re-latch that is missed after a 0-then-1 handshake. Either error appears within one handshake and one read. A stray change of bank or access is visible on `ram_bank` and `clk_access` on the cycle after the offending write.

// File: rtl/rtc_latch_pkg.sv
package rtc_latch_pkg;
  localparam int PAGE_W = 3;
  localparam logic [PAGE_W-1:0] PG_SELECT = 3'd2;
  localparam logic [PAGE_W-1:0] PG_LATCH  = 3'd3;
  localparam logic [PAGE_W-1:0] PG_WINDOW = 3'd5;

  localparam int NREG  = 5;
  localparam int SEL_W = 3;
  localparam int CLK_SEL_BASE = 8;

  typedef enum logic [SEL_W-1:0] {
    REG_SEC   = 3'd0,
    REG_MIN   = 3'd1,
    REG_HOUR  = 3'd2,
    REG_DAYLO = 3'd3,
    REG_DAYHI = 3'd4
  } rtc_reg_e;
endpackage

// File: rtl/rtc_live_counter.sv
module rtc_live_counter
  import rtc_latch_pkg::*;
#(
  parameter int SEC_MAX = 60,
  parameter int MIN_MAX = 60,
  parameter int HR_MAX  = 24,
  parameter int DAY_W   = 9,
  parameter int DATA_W  = 8,
  localparam int SEC_W = $clog2(SEC_MAX),
  localparam int MIN_W = $clog2(MIN_MAX),
  localparam int HR_W  = $clog2(HR_MAX)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              live_wr,
  input  logic [SEL_W-1:0]  reg_sel,
  input  logic [DATA_W-1:0] wdata,
  output logic [SEC_W-1:0]  sec_q,
  output logic [MIN_W-1:0]  min_q,
  output logic [HR_W-1:0]   hr_q,
  output logic [DAY_W-1:0]  day_q,
  output logic              ovf_q
);
  logic sec_wrap, min_wrap, hr_wrap;

  assign sec_wrap = (sec_q == SEC_W'(SEC_MAX - 1));
  assign min_wrap = (min_q == MIN_W'(MIN_MAX - 1));
  assign hr_wrap  = (hr_q  == HR_W'(HR_MAX - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_q <= '0;
      min_q <= '0;
      hr_q  <= '0;
      day_q <= '0;
      ovf_q <= 1'b0;
    end else if (live_wr) begin
      case (reg_sel)
        REG_SEC:   sec_q <= wdata[SEC_W-1:0];
        REG_MIN:   min_q <= wdata[MIN_W-1:0];
        REG_HOUR:  hr_q  <= wdata[HR_W-1:0];
        REG_DAYLO: day_q[DAY_W-2:0] <= wdata[DAY_W-2:0];
        REG_DAYHI: begin
          day_q[DAY_W-1] <= wdata[0];
          ovf_q          <= wdata[DATA_W-1];
        end
        default: ;
      endcase
    end else if (tick) begin
      sec_q <= sec_wrap ? '0 : sec_q + 1'b1;
      if (sec_wrap) begin
        min_q <= min_wrap ? '0 : min_q + 1'b1;
        if (min_wrap) begin
          hr_q <= hr_wrap ? '0 : hr_q + 1'b1;
          if (hr_wrap) begin
            day_q <= day_q + 1'b1;
            if (&day_q) ovf_q <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/rtc_access_ctrl.sv
module rtc_access_ctrl
  import rtc_latch_pkg::*;
#(
  parameter int RAM_BANKS = 4,
  parameter int DATA_W    = 8,
  localparam int BANK_W = $clog2(RAM_BANKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_wr,
  input  logic [PAGE_W-1:0] cpu_page,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [BANK_W-1:0] ram_bank,
  output logic              clk_access,
  output logic [SEL_W-1:0]  reg_sel,
  output logic              latched,
  output logic              snap,
  output logic              live_wr
);
  logic sel_wr, latch_wr, pick_ram, pick_clk;

  assign sel_wr   = cpu_wr && (cpu_page == PG_SELECT);
  assign latch_wr = cpu_wr && (cpu_page == PG_LATCH);
  assign pick_ram = (cpu_wdata < DATA_W'(RAM_BANKS));
  assign pick_clk = (cpu_wdata >= DATA_W'(CLK_SEL_BASE)) &&
                    (cpu_wdata <  DATA_W'(CLK_SEL_BASE + NREG));

  assign snap    = latch_wr && !latched && (cpu_wdata == DATA_W'(1));
  assign live_wr = cpu_wr && (cpu_page == PG_WINDOW) && clk_access;

  always_ff @(posedge clk) begin
    if (rst) begin
      ram_bank   <= '0;
      clk_access <= 1'b0;
      reg_sel    <= '0;
      latched    <= 1'b0;
    end else begin
      if (sel_wr && pick_ram) begin
        ram_bank   <= cpu_wdata[BANK_W-1:0];
        clk_access <= 1'b0;
      end else if (sel_wr && pick_clk) begin
        reg_sel    <= SEL_W'(cpu_wdata - DATA_W'(CLK_SEL_BASE));
        clk_access <= 1'b1;
      end
      if (snap)
        latched <= 1'b1;
      else if (latch_wr && latched && (cpu_wdata == '0))
        latched <= 1'b0;
    end
  end
endmodule

// File: rtl/rtc_snapshot.sv
module rtc_snapshot
  import rtc_latch_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         snap,
  input  logic [NREG-1:0][DATA_W-1:0]  live_fmt,
  input  logic                         rd_en,
  input  logic                         rd_hit,
  input  logic [SEL_W-1:0]             reg_sel,
  output logic [NREG-1:0][DATA_W-1:0]  lat_q,
  output logic [DATA_W-1:0]            rd_data
);
  for (genvar i = 0; i < NREG; i++) begin : g_lat
    always_ff @(posedge clk) begin
      if (rst)       lat_q[i] <= '0;
      else if (snap) lat_q[i] <= live_fmt[i];
    end
  end

  logic [DATA_W-1:0] sel_val;
  always_comb begin
    sel_val = '0;
    for (int k = 0; k < NREG; k++)
      if (reg_sel == SEL_W'(k)) sel_val = lat_q[k];
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_hit ? sel_val : '1;
  end
endmodule

// File: rtl/rtc_latch_top.sv
module rtc_latch_top
  import rtc_latch_pkg::*;
#(
  parameter int SEC_MAX   = 60,
  parameter int MIN_MAX   = 60,
  parameter int HR_MAX    = 24,
  parameter int DAY_W     = 9,
  parameter int DATA_W    = 8,
  parameter int RAM_BANKS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic [2:0]        cpu_page,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic [$clog2(RAM_BANKS)-1:0] ram_bank,
  output logic              clk_access
);
  localparam int SEC_W = $clog2(SEC_MAX);
  localparam int MIN_W = $clog2(MIN_MAX);
  localparam int HR_W  = $clog2(HR_MAX);

  logic [SEL_W-1:0] reg_sel;
  logic latched, snap, live_wr, rd_hit;
  logic [SEC_W-1:0] sec_q;
  logic [MIN_W-1:0] min_q;
  logic [HR_W-1:0]  hr_q;
  logic [DAY_W-1:0] day_q;
  logic ovf_q;
  logic [NREG-1:0][DATA_W-1:0] live_fmt, lat_q;

  rtc_access_ctrl #(.RAM_BANKS(RAM_BANKS), .DATA_W(DATA_W)) u_ctrl (
    .clk, .rst, .cpu_wr, .cpu_page, .cpu_wdata,
    .ram_bank, .clk_access, .reg_sel, .latched, .snap, .live_wr
  );

  rtc_live_counter #(
    .SEC_MAX(SEC_MAX), .MIN_MAX(MIN_MAX), .HR_MAX(HR_MAX),
    .DAY_W(DAY_W), .DATA_W(DATA_W)
  ) u_cnt (
    .clk, .rst, .tick, .live_wr, .reg_sel, .wdata(cpu_wdata),
    .sec_q, .min_q, .hr_q, .day_q, .ovf_q
  );

  always_comb begin
    live_fmt = '0;
    live_fmt[REG_SEC]   = DATA_W'(sec_q);
    live_fmt[REG_MIN]   = DATA_W'(min_q);
    live_fmt[REG_HOUR]  = DATA_W'(hr_q);
    live_fmt[REG_DAYLO] = DATA_W'(day_q[DAY_W-2:0]);
    live_fmt[REG_DAYHI][0]        = day_q[DAY_W-1];
    live_fmt[REG_DAYHI][DATA_W-1] = ovf_q;
  end

  assign rd_hit = (cpu_page == PG_WINDOW) && clk_access;

  rtc_snapshot #(.DATA_W(DATA_W)) u_snap (
    .clk, .rst, .snap, .live_fmt, .rd_en(cpu_rd), .rd_hit, .reg_sel,
    .lat_q, .rd_data
  );
endmodule

// File: rtl/rtc_latch_chk.sv
module rtc_latch_chk
  import rtc_latch_pkg::*;
#(
  parameter int SEC_MAX   = 60,
  parameter int DATA_W    = 8,
  parameter int RAM_BANKS = 4,
  localparam int SEC_W  = $clog2(SEC_MAX),
  localparam int BANK_W = $clog2(RAM_BANKS)
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              cpu_wr,
  input logic [PAGE_W-1:0] cpu_page,
  input logic [DATA_W-1:0] cpu_wdata,
  input logic [BANK_W-1:0] ram_bank,
  input logic              clk_access,
  input logic [SEL_W-1:0]  reg_sel,
  input logic              latched,
  input logic              snap,
  input logic              live_wr,
  input logic [SEC_W-1:0]  sec_q,
  input logic              ovf_q,
  input logic [NREG-1:0][DATA_W-1:0] lat_q
);
  logic rst_seen = 1'b0;
  logic rst_d    = 1'b0;
  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (rst) rst_seen <= 1'b1;
  end

  // R7: state is clear on the first cycle after reset
  always_ff @(posedge clk) begin
    if (rst_seen && rst_d && !rst)
      p_reset_clear_r7: assert (!clk_access && ram_bank == '0 && !latched && !ovf_q
                                && sec_q == '0 && lat_q == '0);
  end

  p_sec_wrap_r1: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (tick && !live_wr && sec_q == SEC_W'(SEC_MAX - 1)) |=> (sec_q == '0));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (ovf_q && !(live_wr && reg_sel == REG_DAYHI)) |=> ovf_q);

  p_sel_ignored_r4: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (cpu_wr && cpu_page == PG_SELECT && cpu_wdata >= DATA_W'(RAM_BANKS) &&
     !(cpu_wdata >= DATA_W'(CLK_SEL_BASE) && cpu_wdata < DATA_W'(CLK_SEL_BASE + NREG)))
    |=> ($stable(clk_access) && $stable(ram_bank)));

  p_snap_copy_r5: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    snap |=> (lat_q[REG_SEC] == DATA_W'($past(sec_q)) && latched));

  p_unlatch_r6: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (cpu_wr && cpu_page == PG_LATCH && cpu_wdata == '0) |=> !latched);

  p_latch_hold_r6: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (latched && !(cpu_wr && cpu_page == PG_LATCH && cpu_wdata == '0))
    |=> (latched && $stable(lat_q)));

  p_live_load_r9: assert property (@(posedge clk) disable iff (rst || !rst_seen)
    (live_wr && reg_sel == REG_SEC) |=> (sec_q == $past(cpu_wdata[SEC_W-1:0])));
endmodule

bind rtc_latch_top rtc_latch_chk #(
  .SEC_MAX(SEC_MAX), .DATA_W(DATA_W), .RAM_BANKS(RAM_BANKS)
) u_chk (.*);

// File: tb/rtc_latch_top_tb.sv
module rtc_latch_top_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, cpu_wr = 1'b0, cpu_rd = 1'b0;
  logic [2:0] cpu_page = '0;
  logic [7:0] cpu_wdata = '0;
  logic [7:0] rd_data;
  logic [1:0] ram_bank;
  logic clk_access;
  int total = 0, bad = 0;
  logic [7:0] rv;

  localparam logic [2:0] SELP = 3'd2, LATP = 3'd3, WINP = 3'd5;

  always #5 clk = ~clk;

  rtc_latch_top u_dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] pg, input logic [7:0] d);
    @(negedge clk); cpu_wr = 1'b1; cpu_page = pg; cpu_wdata = d;
    @(negedge clk); cpu_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] pg, output logic [7:0] d);
    @(negedge clk); cpu_rd = 1'b1; cpu_page = pg;
    @(negedge clk); cpu_rd = 1'b0; d = rd_data;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic relatch();
    wr(LATP, 8'h00); wr(LATP, 8'h01);
  endtask

  task automatic rd_reg(input int idx, output logic [7:0] d);
    wr(SELP, 8'(8 + idx)); rd(WINP, d);
  endtask

  task automatic set_reg(input int idx, input logic [7:0] v);
    wr(SELP, 8'(8 + idx)); wr(WINP, v);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R7 rd_data", rd_data, 8'h00);
    chk("R7 ram_bank", {6'd0, ram_bank}, 8'h00);
    chk("R7 clk_access", {7'd0, clk_access}, 8'h00);
    wr(LATP, 8'h01);
    rd_reg(0, rv); chk("R7 sec zero", rv, 8'h00);
    rd_reg(4, rv); chk("R7 dayhi zero", rv, 8'h00);
  endtask

  task automatic t_select;
    wr(SELP, 8'h02);
    chk("R4 bank 2", {6'd0, ram_bank}, 8'h02);
    chk("R4 access off", {7'd0, clk_access}, 8'h00);
    rd(WINP, rv); chk("R8 no access FF", rv, 8'hFF);
    wr(SELP, 8'h0C);
    chk("R4 access on", {7'd0, clk_access}, 8'h01);
    chk("R4 bank kept", {6'd0, ram_bank}, 8'h02);
    wr(SELP, 8'h05); chk("R4 ignore 05 access", {7'd0, clk_access}, 8'h01);
    wr(SELP, 8'h0D); chk("R4 ignore 0D bank", {6'd0, ram_bank}, 8'h02);
    wr(SELP, 8'h03); wr(SELP, 8'h20);
    chk("R4 ignore 20 bank", {6'd0, ram_bank}, 8'h03);
    chk("R4 ignore 20 access", {7'd0, clk_access}, 8'h00);
  endtask

  task automatic t_count;
    set_reg(0, 8'd58); set_reg(1, 8'd59); set_reg(2, 8'd22);
    ticks(3);
    relatch();
    rd_reg(0, rv); chk("R1 sec wrap", rv, 8'd1);
    rd_reg(1, rv); chk("R1 min wrap", rv, 8'd0);
    rd_reg(2, rv); chk("R1 hour carry", rv, 8'd23);
    rd_reg(3, rv); chk("R1 day unchanged", rv, 8'd0);
  endtask

  task automatic t_frozen;
    ticks(5);
    rd_reg(0, rv); chk("R5 snapshot frozen", rv, 8'd1);
    wr(LATP, 8'h01);
    rd_reg(0, rv); chk("R6 no relatch while latched", rv, 8'd1);
    wr(LATP, 8'h07); wr(LATP, 8'h01);
    rd_reg(0, rv); chk("R6 other value ignored", rv, 8'd1);
    relatch();
    rd_reg(0, rv); chk("R5 relatch new", rv, 8'd6);
  endtask

  task automatic t_overflow;
    set_reg(0, 8'd59); set_reg(1, 8'd59); set_reg(2, 8'd23);
    set_reg(3, 8'hFF); set_reg(4, 8'h01);
    relatch();
    rd_reg(3, rv); chk("R2 day low", rv, 8'hFF);
    rd_reg(4, rv); chk("R2 day bit8 only", rv, 8'h01);
    ticks(1);
    relatch();
    rd_reg(0, rv); chk("R1 full wrap sec", rv, 8'd0);
    rd_reg(2, rv); chk("R1 full wrap hour", rv, 8'd0);
    rd_reg(3, rv); chk("R3 day low wrap", rv, 8'h00);
    rd_reg(4, rv); chk("R3 flag set", rv, 8'h80);
    ticks(2); relatch();
    rd_reg(4, rv); chk("R3 flag sticky", rv, 8'h80);
    set_reg(4, 8'h00); relatch();
    rd_reg(4, rv); chk("R3 flag cleared", rv, 8'h00);
  endtask

  task automatic t_write_beats_tick;
    wr(SELP, 8'h08);
    @(negedge clk); cpu_wr = 1'b1; cpu_page = WINP; cpu_wdata = 8'd10; tick = 1'b1;
    @(negedge clk); cpu_wr = 1'b0; tick = 1'b0;
    relatch();
    rd_reg(0, rv); chk("R9 write wins over tick", rv, 8'd10);
    set_reg(2, 8'hF7); relatch();
    rd_reg(2, rv); chk("R2 hour unused bits zero", rv, 8'h17);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_select();
    t_count();
    t_frozen();
    t_overflow();
    t_write_beats_tick();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #200000;
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule